// File: doc/BRIEF.md
# Dual ADC Parallel Readout Sequencer

This block drives two 16-channel analog-to-digital converters that sit on one shared 16-bit parallel bus. The converters share the data lines, the active-low read strobe, the active-low write strobe and the conversion-start line. Each converter has its own active-low chip select and its own busy input. A single start request fires conversion-start to both converters at once. The block then waits until neither converter reports busy. It reads every channel of converter 0 and then every channel of converter 1, and it presents each result on a valid/index/data stream. A done pulse closes the cycle.

In the idle state the block can also write one configuration word to a selected converter. There is no address bus: the register address travels inside the 16-bit word that is driven onto the data lines. A busy line that stays high too long ends the cycle with a timeout pulse. The busy inputs are taken as synchronous to the clock. Each converter must raise busy while conversion-start is still high.

Top module: `dual_adc_seq`

## Requirements
- R1: After reset both chip selects, the read strobe and the write strobe are high (inactive). Conversion-start, bus drive enable, sample valid, done and timeout are low.
- R2: Suppose start is high at clock edge N while the block is idle. Conversion-start is then high for exactly CONV_W cycles, beginning in the cycle after edge N.
- R3: Neither chip select nor the read strobe goes low for a readout until both busy inputs have been seen low.
- R4: Each cycle delivers exactly 2*NCH samples, all of converter 0 first and then all of converter 1, with channels in ascending order. The index holds the converter number in bit 4 and the channel in bits 3:0. The data is the bus value captured at the clock edge where the read strobe returns high, and valid rises on that same edge.
- R5: The two chip selects are never low together. When the block passes from converter 0 to converter 1, both are high for exactly GAP_W cycles.
- R6: Each read holds the read strobe low for exactly RD_LOW cycles, and only while exactly one chip select is low.
- R7: Done is a one-cycle pulse in the cycle right after the valid of the last sample (index 31).
- R8: If a busy input stays high for BUSY_LIMIT cycles while the block waits, timeout pulses for one cycle and the block returns to idle without reading. With the start condition of R2, the pulse is high in cycle CONV_W+BUSY_LIMIT+1 after edge N.
- R9: Start and write requests that arrive during a cycle have no effect. No extra conversion-start pulse occurs, no write strobe occurs, and the sample count is unchanged.
- R10: A write request in idle pulls the selected converter's chip select low (chip select bit 0 = converter 0) and drives the write word with the bus enable high. It holds the write strobe low for RD_LOW cycles and issues no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion and readout cycle |
| wr_req_i | input | 1 | Request one register write (idle only) |
| wr_dev_i | input | 1 | Target converter for the write |
| wr_word_i | input | 16 | Write word, register address embedded |
| busy_a_i | input | 1 | Busy from converter 0 |
| busy_b_i | input | 1 | Busy from converter 1 |
| bus_d_i | input | 16 | Shared data bus, read direction |
| bus_d_o | output | 16 | Shared data bus, write direction |
| bus_oe_o | output | 1 | Drive enable for bus_d_o |
| cs_n_o | output | 2 | Active-low chip selects, bit 0 = converter 0 |
| rd_n_o | output | 1 | Shared active-low read strobe |
| wr_n_o | output | 1 | Shared active-low write strobe |
| conv_o | output | 1 | Shared conversion-start |
| smp_valid_o | output | 1 | Sample valid |
| smp_idx_o | output | 5 | Converter bit and channel of the sample |
| smp_data_o | output | 16 | Sample value |
| done_o | output | 1 | End-of-cycle pulse |
| tmo_o | output | 1 | Busy timeout pulse |

## Verification
Each check samples on the falling edge, so a result registered at rising edge k appears at the falling edge that follows. Conversion-start is due at the first falling edge after start is taken and lasts CONV_W falling edges. The timeout is due at falling edge CONV_W+BUSY_LIMIT+1, counted exactly. A converter model in the bench counts completed read strobes per chip select and drives a value that encodes the converter and channel. The model advances its count only at the falling edge after the strobe rises, so the value the block captures is the one the bench expects. Done is checked against the sample counter at the falling edge after the 32nd valid.

// File: rtl/dadc_pkg.sv
package dadc_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CONV, ST_WAIT, ST_SETUP, ST_STRB, ST_HOLD,
        ST_GAP, ST_FIN, ST_WSETUP, ST_WSTRB, ST_WHOLD
    } seq_state_e;
endpackage

// File: rtl/dadc_tick_timer.sv
module dadc_tick_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dadc_busy_guard.sv
module dadc_busy_guard #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic busy_a_i,
    input  logic busy_b_i,
    output logic ready_o,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          any_busy;

    assign any_busy = busy_a_i | busy_b_i;

    always_comb begin
        cnt_d = '0;
        if (arm_i && any_busy)
            cnt_d = (cnt_q == CW'(LIMIT)) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o   = !any_busy;
    assign expired_o = arm_i && any_busy && (cnt_q == CW'(LIMIT - 1));

    // R8: the busy counter never runs past its limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
    import dadc_pkg::*;
#(
    parameter int DW         = 16,
    parameter int NCH        = 16,
    parameter int CONV_W     = 2,
    parameter int RD_LOW     = 2,
    parameter int RD_HIGH    = 1,
    parameter int GAP_W      = 1,
    parameter int BUSY_LIMIT = 1000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  wr_req_i,
    input  logic                  wr_dev_i,
    input  logic [DW-1:0]         wr_word_i,
    input  logic                  busy_a_i,
    input  logic                  busy_b_i,
    input  logic [DW-1:0]         bus_d_i,
    output logic [DW-1:0]         bus_d_o,
    output logic                  bus_oe_o,
    output logic [1:0]            cs_n_o,
    output logic                  rd_n_o,
    output logic                  wr_n_o,
    output logic                  conv_o,
    output logic                  smp_valid_o,
    output logic [$clog2(NCH):0]  smp_idx_o,
    output logic [DW-1:0]         smp_data_o,
    output logic                  done_o,
    output logic                  tmo_o
);
    localparam int CHW  = $clog2(NCH);
    localparam int T1   = (CONV_W > RD_LOW) ? CONV_W : RD_LOW;
    localparam int T2   = (RD_HIGH > GAP_W) ? RD_HIGH : GAP_W;
    localparam int TMAX = (T1 > T2) ? T1 : T2;
    localparam int TW   = $clog2(TMAX + 1) + 1;

    typedef struct packed {
        seq_state_e     st;
        logic           dev;
        logic [CHW-1:0] ch;
        logic [1:0]     cs_n;
        logic           rd_n;
        logic           wr_n;
        logic           conv;
        logic           oe;
        logic [DW-1:0]  dout;
        logic           vld;
        logic [CHW:0]   idx;
        logic [DW-1:0]  smp;
        logic           done;
        logic           tmo;
    } seq_regs_t;

    seq_regs_t d, q;

    logic          tm_load;
    logic [TW-1:0] tm_val;
    logic          tm_zero;
    logic          bs_ready;
    logic          bs_expired;
    logic          last_ch;

    dadc_tick_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tm_load),
        .val_i  (tm_val),
        .zero_o (tm_zero)
    );

    dadc_busy_guard #(.LIMIT(BUSY_LIMIT)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (q.st == ST_WAIT),
        .busy_a_i  (busy_a_i),
        .busy_b_i  (busy_b_i),
        .ready_o   (bs_ready),
        .expired_o (bs_expired)
    );

    assign last_ch = (q.ch == CHW'(NCH - 1));

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.done  = 1'b0;
        d.tmo   = 1'b0;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_CONV;
                    d.conv  = 1'b1;
                    tm_load = 1'b1;
                    tm_val  = TW'(CONV_W - 1);
                end else if (wr_req_i) begin
                    d.st             = ST_WSETUP;
                    d.cs_n           = 2'b11;
                    d.cs_n[wr_dev_i] = 1'b0;
                    d.oe             = 1'b1;
                    d.dout           = wr_word_i;
                end
            end
            ST_CONV: begin
                if (tm_zero) begin
                    d.conv = 1'b0;
                    d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bs_ready) begin
                    d.st   = ST_SETUP;
                    d.dev  = 1'b0;
                    d.ch   = '0;
                    d.cs_n = 2'b10;
                end else if (bs_expired) begin
                    d.st  = ST_IDLE;
                    d.tmo = 1'b1;
                end
            end
            ST_SETUP: begin
                d.st    = ST_STRB;
                d.rd_n  = 1'b0;
                tm_load = 1'b1;
                tm_val  = TW'(RD_LOW - 1);
            end
            ST_STRB: begin
                if (tm_zero) begin
                    d.rd_n = 1'b1;
                    d.vld  = 1'b1;
                    d.idx  = {q.dev, q.ch};
                    d.smp  = bus_d_i;
                    if (last_ch) begin
                        d.cs_n = 2'b11;
                        if (!q.dev) begin
                            d.st    = ST_GAP;
                            tm_load = 1'b1;
                            tm_val  = TW'(GAP_W - 1);
                        end else begin
                            d.st = ST_FIN;
                        end
                    end else begin
                        d.st    = ST_HOLD;
                        tm_load = 1'b1;
                        tm_val  = TW'(RD_HIGH - 1);
                    end
                end
            end
            ST_HOLD: begin
                if (tm_zero) begin
                    d.st    = ST_STRB;
                    d.rd_n  = 1'b0;
                    d.ch    = q.ch + 1'b1;
                    tm_load = 1'b1;
                    tm_val  = TW'(RD_LOW - 1);
                end
            end
            ST_GAP: begin
                if (tm_zero) begin
                    d.st   = ST_SETUP;
                    d.dev  = 1'b1;
                    d.ch   = '0;
                    d.cs_n = 2'b01;
                end
            end
            ST_FIN: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            ST_WSETUP: begin
                d.st    = ST_WSTRB;
                d.wr_n  = 1'b0;
                tm_load = 1'b1;
                tm_val  = TW'(RD_LOW - 1);
            end
            ST_WSTRB: begin
                if (tm_zero) begin
                    d.st    = ST_WHOLD;
                    d.wr_n  = 1'b1;
                    tm_load = 1'b1;
                    tm_val  = TW'(RD_HIGH - 1);
                end
            end
            ST_WHOLD: begin
                if (tm_zero) begin
                    d.st   = ST_IDLE;
                    d.cs_n = 2'b11;
                    d.oe   = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 2'b11;
            q.rd_n <= 1'b1;
            q.wr_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bus_d_o     = q.dout;
    assign bus_oe_o    = q.oe;
    assign cs_n_o      = q.cs_n;
    assign rd_n_o      = q.rd_n;
    assign wr_n_o      = q.wr_n;
    assign conv_o      = q.conv;
    assign smp_valid_o = q.vld;
    assign smp_idx_o   = q.idx;
    assign smp_data_o  = q.smp;
    assign done_o      = q.done;
    assign tmo_o       = q.tmo;

    a_r5_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o != 2'b00);

    a_r5_gap_to_b: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o[1] |-> $past(cs_n_o[0]));

    a_r5_gap_to_a: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o[0] |-> $past(cs_n_o[1]));

    a_r3_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o[0]) && !bus_oe_o) |-> $past(!busy_a_i && !busy_b_i));

    a_r6_rd_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> ($countones(~cs_n_o) == 1));

    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(smp_valid_o) && ($past(smp_idx_o) == {(CHW+1){1'b1}})));

    a_r8_tmo_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> ($past(busy_a_i || busy_b_i) && (cs_n_o == 2'b11)));

    a_r10_wr_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (bus_oe_o && rd_n_o && !conv_o));
endmodule

// File: tb/tb_dual_adc_seq.sv
module tb_dual_adc_seq;
    localparam int CONV_W = 2, RD_LOW = 2, RD_HIGH = 1, GAP_W = 1, LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, wr_req = 1'b0, wr_dev = 1'b0;
    logic [15:0] wr_word = '0;
    logic        busy_a, busy_b;
    logic [15:0] bus_in, bus_out;
    logic        oe, rd_n, wr_n, conv, vld, done, tmo;
    logic [1:0]  cs_n;
    logic [4:0]  idx;
    logic [15:0] sdata;

    always #10 clk = ~clk;

    dual_adc_seq #(.CONV_W(CONV_W), .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH),
                   .GAP_W(GAP_W), .BUSY_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wr_req_i(wr_req),
        .wr_dev_i(wr_dev), .wr_word_i(wr_word), .busy_a_i(busy_a),
        .busy_b_i(busy_b), .bus_d_i(bus_in), .bus_d_o(bus_out),
        .bus_oe_o(oe), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
        .conv_o(conv), .smp_valid_o(vld), .smp_idx_o(idx),
        .smp_data_o(sdata), .done_o(done), .tmo_o(tmo));

    // seed, busy length A, busy length B
    localparam logic [47:0] VEC [0:3] = '{
        48'h1000_0003_0005, 48'hA5A5_0007_0001,
        48'h0F00_0001_0001, 48'hFFF0_0014_000C };

    int nchk = 0, nerr = 0, cyc = 0;
    logic [15:0] seed = '0;
    int da = 0, db = 0, ra = 0, rb = 0;
    int cnt0 = 0, cnt1 = 0, nsmp = 0, convs = 0, conv_run = 0, dones = 0;
    int low_run = 0, hi_run = 0, early = 0, badw = 0, gap_bad = 0;
    int wr_lows = 0, wr_bad = 0;
    logic prev_rd = 1'b1, prev_conv = 1'b0, prev_vld = 1'b0;
    logic [1:0] prev_cs = 2'b11;

    assign busy_a = (ra != 0);
    assign busy_b = (rb != 0);

    function automatic logic [15:0] pat(input int k);
        return seed + 16'(k) * 16'h0101;
    endfunction

    assign bus_in = (cs_n == 2'b10) ? pat(cnt0) :
                    (cs_n == 2'b01) ? pat(16 + cnt1) : 16'hDEAD;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // converter model and monitors, all at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!rd_n && (busy_a || busy_b)) early++;               // R3
            if (!rd_n) low_run++;
            if (rd_n && !prev_rd) begin                            // R6
                if (low_run != RD_LOW) badw++;
                low_run = 0;
                if (cs_n == 2'b10) cnt0++;
                else if (cs_n == 2'b01) cnt1++;
            end
            if (cs_n == 2'b11) hi_run++;
            if (prev_cs == 2'b10 && cs_n == 2'b01) gap_bad++;     // R5
            if (prev_cs == 2'b11 && cs_n == 2'b01 && hi_run != GAP_W) gap_bad++;
            if (cs_n != 2'b11) hi_run = 0;
            if (!wr_n) begin                                        // R10
                wr_lows++;
                if (cs_n != 2'b01 || bus_out != 16'h8123 || !oe || !rd_n) wr_bad++;
            end
            if (vld) begin                                          // R4
                chk(idx == 5'(nsmp) && sdata == pat(nsmp), "R4", "sample",
                    {idx, sdata}, {5'(nsmp), pat(nsmp)});
                nsmp++;
            end
            if (done) begin                                         // R7
                dones++;
                chk(prev_vld && nsmp == 32, "R7", "done position", nsmp, 32);
            end
            if (conv) conv_run++;
            if (!conv && prev_conv) begin                           // R2
                chk(conv_run == CONV_W, "R2", "conv width", conv_run, CONV_W);
                conv_run = 0;
            end
            if (conv && !prev_conv) begin
                convs++;
                cnt0 = 0; cnt1 = 0;
                ra = da; rb = db;
            end else begin
                if (ra > 0) ra--;
                if (rb > 0) rb--;
            end
        end
        prev_rd = rd_n; prev_conv = conv; prev_vld = vld; prev_cs = cs_n;
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic clear_stats();
        nsmp = 0; convs = 0; dones = 0; early = 0; badw = 0;
        gap_bad = 0; wr_lows = 0; wr_bad = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 2'b11 && rd_n && wr_n && !conv && !oe, "R1", "bus idle",
            {cs_n, rd_n, wr_n, conv, oe}, 6'b111100);
        chk(!vld && !done && !tmo, "R1", "stream idle", {vld, done, tmo}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 4; i++) begin
            seed = VEC[i][47:32]; da = int'(VEC[i][31:16]); db = int'(VEC[i][15:0]);
            clear_stats();
            start = 1'b1; @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            // R9: requests during a cycle are ignored
            start = 1'b1; wr_req = 1'b1; wr_dev = 1'b1; wr_word = 16'h8123;
            @(negedge clk);
            start = 1'b0; wr_req = 1'b0;
            for (int w = 0; w < 2000 && dones == 0; w++) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(nsmp == 32, "R4", "sample count", nsmp, 32);
            chk(dones == 1, "R7", "done count", dones, 1);
            chk(convs == 1, "R9", "conv pulses", convs, 1);
            chk(wr_lows == 0, "R9", "write strobes", wr_lows, 0);
            chk(early == 0, "R3", "reads while busy", early, 0);
            chk(gap_bad == 0, "R5", "chip select gap", gap_bad, 0);
            chk(badw == 0, "R6", "strobe width", badw, 0);
        end

        // R8 timeout with a stuck busy line, R2 start-to-conv latency
        begin
            int t_conv, t_tmo;
            clear_stats(); da = 100000; db = 2; t_conv = -1; t_tmo = -1;
            start = 1'b1; @(negedge clk); start = 1'b0;
            for (int k = 1; k < 200 && t_tmo < 0; k++) begin
                if (conv && t_conv < 0) t_conv = k;
                if (tmo) t_tmo = k;
                @(negedge clk);
            end
            chk(t_conv == 1, "R2", "conv latency", t_conv, 1);
            chk(t_tmo == CONV_W + LIMIT + 1, "R8", "timeout cycle", t_tmo, CONV_W + LIMIT + 1);
            repeat (3) @(negedge clk);
            chk(nsmp == 0 && cs_n == 2'b11, "R8", "no reads after timeout", nsmp, 0);
            da = 0; db = 0; ra = 0; rb = 0;
        end

        // R10 register write to converter 1
        clear_stats();
        wr_req = 1'b1; wr_dev = 1'b1; wr_word = 16'h8123;
        @(negedge clk); wr_req = 1'b0;
        repeat (10) @(negedge clk);
        chk(wr_lows == RD_LOW, "R10", "write strobe width", wr_lows, RD_LOW);
        chk(wr_bad == 0, "R10", "write bus drive", wr_bad, 0);
        chk(convs == 0 && nsmp == 0, "R10", "no conv or read", convs + nsmp, 0);
        chk(cs_n == 2'b11 && !oe, "R10", "released", {cs_n, oe}, 3'b110);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule